// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

The block gathers a set of device interrupt request lines and one non-maskable request. It keeps a record of which requests are pending, holds back those that are masked or that arrive while interrupts are globally off, and chooses the most urgent request that may be delivered. The chosen request goes to the CPU as a vector number on a valid/ready handshake.

When the CPU accepts a vector, that request leaves the pending set and enters the in-service set. A request that is in service holds off every request of equal or lower priority until the CPU writes end-of-interrupt (EOI). A small register port sets the per-line masks, the trigger mode of each line, the global enable and the vector base, and it carries the EOI write.

Handshake rules: once `vec_valid_o` rises, `vec_o` stays fixed until the cycle in which `vec_ready_i` is also high. That is the only cycle in which a transfer happens. The CPU may hold `vec_ready_i` low for as long as it likes, and nothing is lost while it does. A more urgent request that arrives during the wait is offered after the current vector is accepted. `vec_valid_o` is low in the cycle after an acceptance.

Top module: `irq_prio_ctrl`

## Requirements
- R1: At most one vector is offered at a time. While `vec_valid_o` is high and `vec_ready_i` is low, `vec_o` and `vec_valid_o` hold. `vec_valid_o` is low in the cycle after an accepted transfer.
- R2: Among eligible device lines, the lowest index wins. Line 0 is the most urgent, line 1 is next, and so on. The non-maskable request outranks every device line.
- R3: A device line is not offered while that line or any more urgent line is in service, or while the non-maskable request is in service. A strictly more urgent line is still offered.
- R4: Writing address 0 sets the masks: bit i at 1 masks line i. Bit 8 of address 2 is the global enable, and 0 means disabled. A masked or disabled request is not offered, but it remains pending and is offered once it becomes eligible.
- R5: The non-maskable request is delivered whatever the masks and the global enable are, and its vector is always 2.
- R6: The non-maskable input is edge-detected. A second rising edge that comes while the non-maskable request is in service is held, and it is offered only after an EOI retires the first.
- R7: A device vector equals base plus line index, modulo 256. The base is bits 7:0 of address 2 and resets to 32.
- R8: Accepting a vector puts that request in service. Any write to address 3 is an EOI. An EOI retires the non-maskable request if it is in service, and otherwise the lowest-index device line in service.
- R9: Address 1 sets the trigger mode: bit i at 1 makes line i edge-triggered, and 0 makes it level-triggered. An edge line becomes pending on a rising edge and stays pending until accepted. A level line requests while it is high, so a line still high after EOI is offered again, and a line that has dropped is not.
- R10: After reset no vector is offered, all masks are clear, all lines are level-triggered, the global enable is off and the base is 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| irq_i | input | NUM_LINES | Device request lines, synchronous to clk |
| nmi_i | input | 1 | Non-maskable request, synchronous to clk |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register address: 0 masks, 1 modes, 2 enable and base, 3 EOI |
| cfg_wdata_i | input | max(NUM_LINES,9) | Register write data |
| vec_valid_o | output | 1 | A vector is offered |
| vec_o | output | 8 | Offered vector number |
| vec_ready_i | input | 1 | CPU accepts the offered vector |

## Verification
Wrong in-service state shows up as one of two faults at the ports. The controller may stay silent where a more urgent line should preempt, or it may offer a line that an equal or more urgent line in service should hold off. Either fault appears within about three cycles of the request or of the EOI that should release it. Wrong pending state shows up as a request that vanishes after a mask, a disable or an EOI, or as a request that repeats after its level line has dropped. The scoreboard pairs every accepted vector with the vector the requirements predict, in order, so a wrong priority choice or a wrong base sum shows up at the first transfer it affects. Idle windows confirm that held-off requests are truly withheld.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  localparam int VEC_W = 8;
  typedef logic [VEC_W-1:0] vec_t;
  localparam vec_t NMI_VEC = 8'd2;

  typedef enum logic [1:0] {
    REG_MASK = 2'd0,
    REG_MODE = 2'd1,
    REG_CTRL = 2'd2,
    REG_EOI  = 2'd3
  } cfg_addr_e;

  function automatic vec_t dev_vec(input vec_t base, input int idx);
    return vec_t'(base + vec_t'(idx));
  endfunction
endpackage

// File: rtl/ipc_pend_latch.sv
module ipc_pend_latch #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq,
  input  logic         nmi,
  input  logic [N-1:0] edge_mode,
  input  logic [N-1:0] clr_line,
  input  logic         clr_nmi,
  output logic [N-1:0] req,
  output logic         nmi_req
);
  logic [N-1:0] prev_irq, latch_q;
  logic         prev_nmi, nmi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_irq <= '0;
      latch_q  <= '0;
      prev_nmi <= 1'b0;
      nmi_q    <= 1'b0;
    end else begin
      prev_irq <= irq;
      prev_nmi <= nmi;
      latch_q  <= (latch_q & ~clr_line) | (irq & ~prev_irq & edge_mode);
      nmi_q    <= (nmi_q & ~clr_nmi) | (nmi & ~prev_nmi);
    end
  end

  assign req     = (latch_q & edge_mode) | (irq & ~edge_mode);
  assign nmi_req = nmi_q;

  AST_NMI_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi && !prev_nmi) |=> nmi_q) else $error("nmi edge lost"); // R6

  for (genvar g = 0; g < N; g++) begin : g_chk
    AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode[g] && irq[g] && !prev_irq[g]) |=> latch_q[g]) else $error("edge lost"); // R9
  end
endmodule

// File: rtl/ipc_svc_track.sv
module ipc_svc_track #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_line,
  input  logic         set_nmi,
  input  logic         eoi,
  output logic [N-1:0] blk,
  output logic         nmi_busy
);
  localparam logic [N-1:0] ONE = 1;

  logic [N-1:0] isr_q, lowest, clr_dev;
  logic         nmi_isr_q;

  assign lowest  = isr_q & (~isr_q + ONE);
  assign clr_dev = (eoi && !nmi_isr_q) ? lowest : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q     <= '0;
      nmi_isr_q <= 1'b0;
    end else begin
      isr_q     <= (isr_q & ~clr_dev) | set_line;
      nmi_isr_q <= (nmi_isr_q & ~eoi) | set_nmi;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_blk
    if (g == 0) begin : g_first
      assign blk[g] = nmi_isr_q | isr_q[g];
    end else begin : g_rest
      assign blk[g] = blk[g-1] | isr_q[g];
    end
  end

  assign nmi_busy = nmi_isr_q;

  AST_NO_EQ_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
    (set_line & blk) == '0) else $error("blocked line entered service"); // R3
  AST_NMI_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    set_nmi |-> !nmi_isr_q) else $error("nested nmi"); // R6
  AST_EOI_NMI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && nmi_isr_q) |=> (!nmi_isr_q && isr_q == $past(isr_q | set_line))) else $error("eoi order"); // R8
endmodule

// File: rtl/ipc_arbiter.sv
module ipc_arbiter #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     elig,
  input  logic             nmi_elig,
  output logic             pick_any,
  output logic             pick_nmi,
  output logic [IDX_W-1:0] pick_idx
);
  always_comb begin
    pick_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) pick_idx = IDX_W'(i);
    end
    pick_nmi = nmi_elig;
    pick_any = nmi_elig | (|elig);
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import ipc_pkg::*;
#(
  parameter int   NUM_LINES  = 8,
  parameter vec_t RESET_BASE = 8'd32,
  localparam int  DW         = (NUM_LINES > 9) ? NUM_LINES : 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_i,
  input  logic                 nmi_i,
  input  logic                 cfg_we_i,
  input  logic [1:0]           cfg_addr_i,
  input  logic [DW-1:0]        cfg_wdata_i,
  output logic                 vec_valid_o,
  output logic [VEC_W-1:0]     vec_o,
  input  logic                 vec_ready_i
);
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam logic [NUM_LINES-1:0] ONE_L = 1;

  logic [NUM_LINES-1:0] mask_q, mode_q;
  logic                 en_q;
  vec_t                 base_q;

  logic                 valid_q, offer_nmi;
  vec_t                 offer_vec;
  logic [IDX_W-1:0]     offer_idx;

  logic                 accept, wr_eoi;
  logic [NUM_LINES-1:0] clr_line, req, blk, elig;
  logic                 nmi_req, nmi_busy, nmi_elig;
  logic                 pick_any, pick_nmi;
  logic [IDX_W-1:0]     pick_idx;

  // register port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      mode_q <= '0;
      en_q   <= 1'b0;
      base_q <= RESET_BASE;
    end else if (cfg_we_i) begin
      case (cfg_addr_e'(cfg_addr_i))
        REG_MASK: mask_q <= cfg_wdata_i[NUM_LINES-1:0];
        REG_MODE: mode_q <= cfg_wdata_i[NUM_LINES-1:0];
        REG_CTRL: begin
          en_q   <= cfg_wdata_i[8];
          base_q <= cfg_wdata_i[7:0];
        end
        default: ;
      endcase
    end
  end

  assign wr_eoi = cfg_we_i && (cfg_addr_i == REG_EOI);
  assign accept = valid_q && vec_ready_i;

  always_comb begin
    clr_line = '0;
    if (accept && !offer_nmi) clr_line[offer_idx] = 1'b1;
  end

  ipc_pend_latch #(.N(NUM_LINES)) pend_i (
    .clk(clk), .rst_n(rst_n), .irq(irq_i), .nmi(nmi_i), .edge_mode(mode_q),
    .clr_line(clr_line), .clr_nmi(accept && offer_nmi),
    .req(req), .nmi_req(nmi_req)
  );

  ipc_svc_track #(.N(NUM_LINES)) svc_i (
    .clk(clk), .rst_n(rst_n), .set_line(clr_line), .set_nmi(accept && offer_nmi),
    .eoi(wr_eoi), .blk(blk), .nmi_busy(nmi_busy)
  );

  assign elig     = req & ~mask_q & {NUM_LINES{en_q}} & ~blk;
  assign nmi_elig = nmi_req & ~nmi_busy;

  ipc_arbiter #(.N(NUM_LINES), .IDX_W(IDX_W)) arb_i (
    .elig(elig), .nmi_elig(nmi_elig),
    .pick_any(pick_any), .pick_nmi(pick_nmi), .pick_idx(pick_idx)
  );

  // offer register: the vector is frozen from load until acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      offer_nmi <= 1'b0;
      offer_idx <= '0;
      offer_vec <= '0;
    end else if (accept) begin
      valid_q <= 1'b0;
    end else if (!valid_q && pick_any) begin
      valid_q   <= 1'b1;
      offer_nmi <= pick_nmi;
      offer_idx <= pick_idx;
      offer_vec <= pick_nmi ? NMI_VEC : dev_vec(base_q, int'(pick_idx));
    end
  end

  assign vec_valid_o = valid_q;
  assign vec_o       = offer_vec;

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid_o && !vec_ready_i) |=> (vec_valid_o && $stable(vec_o))) else $error("offer moved"); // R1
  AST_DROP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid_o && vec_ready_i) |=> !vec_valid_o) else $error("valid stuck"); // R1
  AST_MASKED_NO_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(vec_valid_o) && !offer_nmi) |->
      ($past(en_q) && (($past(mask_q) & (ONE_L << offer_idx)) == '0))) else $error("masked offer"); // R4
endmodule

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;
  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [N-1:0] irq_i = '0;
  logic       nmi_i = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [1:0] cfg_addr_i = '0;
  logic [8:0] cfg_wdata_i = '0;
  logic       vec_valid_o;
  logic [7:0] vec_o;
  logic       vec_ready_i = 1'b0;

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk; // 50 MHz

  irq_prio_ctrl #(.NUM_LINES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .nmi_i(nmi_i),
    .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
    .vec_valid_o(vec_valid_o), .vec_o(vec_o), .vec_ready_i(vec_ready_i)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: compares each transfer against the scoreboard
  always @(negedge clk) begin
    if (rst_n && vec_valid_o && vec_ready_i) begin
      if (exp_q.size() == 0) check(1'b0, "R1 unexpected transfer", vec_o, -1);
      else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(vec_o == e[7:0], t, vec_o, e);
      end
    end
  end

  task automatic cfg_wr(input logic [1:0] a, input logic [8:0] d);
    @(posedge clk); #1;
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(posedge clk); #1;
    cfg_we_i = 1'b0;
  endtask

  task automatic eoi();
    cfg_wr(2'd3, 9'd0);
  endtask

  task automatic pulse(input logic [N-1:0] m);
    @(posedge clk); #1; irq_i = irq_i | m;
    @(posedge clk); #1; irq_i = irq_i & ~m;
  endtask

  task automatic nmi_pulse();
    @(posedge clk); #1; nmi_i = 1'b1;
    @(posedge clk); #1; nmi_i = 1'b0;
  endtask

  // driver: pushes the expectation, then accepts the next offer
  task automatic take(input int expv, input string tag);
    bit seen = 1'b0;
    exp_q.push_back(expv);
    tag_q.push_back(tag);
    for (int k = 0; k < 30 && !seen; k++) begin
      @(negedge clk);
      if (vec_valid_o) seen = 1'b1;
    end
    if (!seen) begin
      check(1'b0, {tag, " no offer"}, 0, expv);
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end else begin
      @(posedge clk); #1; vec_ready_i = 1'b1;
      @(posedge clk); #1; vec_ready_i = 1'b0;
      @(negedge clk);
      check(!vec_valid_o, "R1 valid low after accept", vec_valid_o, 0);
    end
  endtask

  task automatic idle(input int n, input string tag);
    bit quiet = 1'b1;
    int seenv = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (vec_valid_o) begin quiet = 1'b0; seenv = vec_o; end
    end
    check(quiet, tag, seenv, -1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!vec_valid_o, "R10 no offer after reset", vec_valid_o, 0);

    // R10/R4: enable is off after reset; request waits
    cfg_wr(2'd1, 9'h0FF);
    pulse(8'h08);
    idle(6, "R10 enable off after reset");
    cfg_wr(2'd2, 9'h120);
    take(35, "R4 pending survives disable");
    eoi();

    // R2: two lines at once, lower index first; R3 blocks the other
    pulse(8'h24);
    take(34, "R2 lowest index wins");
    idle(5, "R3 lower priority held");
    eoi();
    take(37, "R3 released by EOI");
    eoi();

    // R3 preemption by a strictly higher line, R8 EOI order
    pulse(8'h10);
    take(36, "R3 line4");
    pulse(8'h40);
    idle(5, "R3 line6 held by line4");
    pulse(8'h02);
    take(33, "R3 higher preempts");
    eoi();
    idle(5, "R8 EOI retired line1 only");
    eoi();
    take(38, "R8 line6 after second EOI");
    eoi();

    // R3 equal priority held
    pulse(8'h04);
    take(34, "R3 line2 first");
    pulse(8'h04);
    idle(5, "R3 equal priority held");
    eoi();
    take(34, "R3 line2 again after EOI");
    eoi();

    // R4 mask
    cfg_wr(2'd0, 9'h001);
    pulse(8'h01);
    idle(5, "R4 masked line withheld");
    cfg_wr(2'd0, 9'h000);
    take(32, "R4 delivered after unmask");
    eoi();

    // R1 back-pressure: offer holds while a more urgent line arrives
    pulse(8'h20);
    repeat (3) @(negedge clk);
    check(vec_valid_o && vec_o == 8'd37, "R1 offer line5", vec_o, 37);
    pulse(8'h01);
    repeat (3) @(negedge clk);
    check(vec_valid_o && vec_o == 8'd37, "R1 offer stable under back-pressure", vec_o, 37);
    take(37, "R1 held vector accepted");
    take(32, "R2 urgent line after accept");
    eoi();
    eoi();

    // R5/R6 non-maskable
    cfg_wr(2'd2, 9'h020);
    cfg_wr(2'd0, 9'h0FF);
    nmi_pulse();
    take(2, "R5 nmi ignores enable and masks");
    nmi_pulse();
    idle(5, "R6 second nmi held");
    eoi();
    take(2, "R6 second nmi after EOI");
    eoi();
    idle(4, "R6 nmi retired");

    // R9 level line re-request
    cfg_wr(2'd0, 9'h000);
    cfg_wr(2'd2, 9'h120);
    cfg_wr(2'd1, 9'h07F);
    @(posedge clk); #1; irq_i[7] = 1'b1;
    take(39, "R9 level line");
    eoi();
    take(39, "R9 level re-request after EOI");
    @(posedge clk); #1; irq_i[7] = 1'b0;
    eoi();
    idle(6, "R9 dropped level line silent");

    // R7 base
    cfg_wr(2'd1, 9'h0FF);
    cfg_wr(2'd2, 9'h180);
    pulse(8'h08);
    take(131, "R7 base 0x80 plus 3");
    eoi();
    cfg_wr(2'd2, 9'h1FE);
    pulse(8'h08);
    take(1, "R7 base wraps modulo 256");
    eoi();

    idle(4, "R8 all retired");
    check(exp_q.size() == 0, "R1 scoreboard drained", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule